// File: doc/BRIEF.md
# Cascadable Programmable Divide-by-N Counter

This block is a synchronous binary up-counter, eight bits wide by default. It has an active-low count enable and a synchronous parallel load from a preset input. A combinational active-low terminal-count output goes low whenever every count bit is 1. An active-low enable input accepts that signal directly, so several instances can be chained into wider counters. In the chain, each stage's enable is the terminal count of the stage below it, or the OR of the terminal counts of all lower stages.

When the reload-on-terminal-count control is set, the counter loads the preset value instead of wrapping to zero. The reload takes place on the edge that would otherwise carry the counter from all ones to zero. The counter then repeats a cycle of 2^WIDTH minus preset states, which makes it a programmable frequency divider that runs at the full clock rate. For example, a preset of 143 gives a ratio of 113 and a preset of 0 gives a ratio of 256. A registered one-clock pulse marks each pass through the top of the count and serves as the divided output.

Top module: `prog_div_counter`

## Requirements
- R1: While rst_n is low, count is 0, tc_n is 1 and div_pulse is 0.
- R2: With load_en low and cnt_en_n low, count increases by one on each rising edge. With reload_on_tc low, count wraps from all ones to 0.
- R3: With load_en low and cnt_en_n high, count holds its value, whatever preset and reload_on_tc do.
- R4: With load_en high, count takes preset on the next rising edge. This load overrides cnt_en_n and reload_on_tc, even when count is all ones.
- R5: tc_n is 0 in exactly those cycles where count is all ones, and 1 otherwise, with no register delay.
- R6: With reload_on_tc high, load_en low and cnt_en_n low, a rising edge at which count is all ones loads preset into count instead of 0.
- R7: div_pulse is 1 for exactly the one cycle after an edge at which count advanced from all ones while enabled and not loading. With reload active and preset P, pulses recur every 2^WIDTH minus P clocks: 113 for P=143, 256 for P=0, 56 for P=200 and 1 for P=255.
- R8: Four instances chained as follows form a 32-bit counter that matches a binary reference, including at byte and full-width rollovers. Stage 0 is always enabled. Each higher stage's cnt_en_n is the OR of the tc_n outputs of all lower stages. All stages load together. Stage k drives bits 8k+7..8k.
- R9: When count is all ones and cnt_en_n is high, count stays all ones, no reload happens and div_pulse stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_n | input | 1 | Active-low count enable |
| load_en | input | 1 | Active-high synchronous parallel load |
| reload_on_tc | input | 1 | Reload preset instead of wrapping at all ones |
| preset | input | WIDTH | Parallel load and reload value |
| count | output | WIDTH | Current count |
| tc_n | output | 1 | Active-low terminal count, low when count is all ones |
| div_pulse | output | 1 | One-clock pulse after each advance out of all ones |

## Verification
Inputs take effect on the first rising edge after they are applied, so count and div_pulse are due one edge later, while tc_n follows count in the same cycle. The bench drives every input at the falling edge. The driver pushes the expected count and pulse for the coming rising edge into a queue, and a monitor pops that item 5 ns after the edge and compares it. Divider periods are taken as the difference in cycle number between consecutive observed pulses. The cascade is compared against a 32-bit reference at the same sampling point after every edge.

// File: rtl/prog_div_counter.sv
module prog_div_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_n,
  input  logic             load_en,
  input  logic             reload_on_tc,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             tc_n,
  output logic             div_pulse
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic             at_top;
  logic             advance;
  logic [WIDTH-1:0] next_val;

  assign at_top   = (count == ALL_ONES);
  assign tc_n     = ~at_top;
  assign advance  = ~load_en & ~cnt_en_n;
  assign next_val = (reload_on_tc && at_top) ? preset : count + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= advance & at_top;
      if (load_en)
        count <= preset;
      else if (advance)
        count <= next_val;
    end
  end

endmodule

// File: rtl/prog_div_counter_chk.sv
module prog_div_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en_n,
  input logic             load_en,
  input logic             reload_on_tc,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             tc_n,
  input logic             div_pulse
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !cnt_en_n && !(reload_on_tc && count == ALL_ONES))
      |=> count == WIDTH'($past(count) + WIDTH'(1)));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && cnt_en_n) |=> $stable(count));

  // R4
  par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> count == $past(preset));

  // R6
  tc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !cnt_en_n && reload_on_tc && count == ALL_ONES)
      |=> count == $past(preset));

  // R7
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_pulse) |-> ($past(!tc_n) && $past(!cnt_en_n) && $past(!load_en)));

  // R9
  idle_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_n && cnt_en_n && !load_en) |=> (!tc_n && !div_pulse));

endmodule

bind prog_div_counter prog_div_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .load_en(load_en),
  .reload_on_tc(reload_on_tc), .preset(preset), .count(count),
  .tc_n(tc_n), .div_pulse(div_pulse)
);

// File: tb/test_prog_div_counter.sv
`timescale 1ns/1ps
module test_prog_div_counter;

  localparam int HALF = 10;

  typedef struct {
    string      tag;
    logic [7:0] cnt;
    logic       pulse;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en_n = 1'b1;
  logic       load_en = 1'b0;
  logic       reload_on_tc = 1'b0;
  logic [7:0] preset = '0;
  logic [7:0] count;
  logic       tc_n;
  logic       div_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int prev_pulse = -1;
  int measured = 0;
  logic [7:0] m_cnt = '0;
  exp_t q[$];

  always #HALF clk = ~clk;

  prog_div_counter #(.WIDTH(8)) i_prog_div_counter (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .load_en(load_en),
    .reload_on_tc(reload_on_tc), .preset(preset), .count(count),
    .tc_n(tc_n), .div_pulse(div_pulse)
  );

  // 32-bit cascade for R8
  logic        c_load = 1'b0;
  logic [31:0] c_pre = '0;
  logic [31:0] c_cnt;
  logic [3:0]  c_tc_n;
  logic [3:0]  c_en_n;
  logic [3:0]  c_pulse;

  assign c_en_n[0] = 1'b0;
  assign c_en_n[1] = c_tc_n[0];
  assign c_en_n[2] = c_tc_n[0] | c_tc_n[1];
  assign c_en_n[3] = c_tc_n[0] | c_tc_n[1] | c_tc_n[2];

  for (genvar k = 0; k < 4; k++) begin : g_stage
    prog_div_counter #(.WIDTH(8)) i_stage (
      .clk(clk), .rst_n(rst_n), .cnt_en_n(c_en_n[k]), .load_en(c_load),
      .reload_on_tc(1'b0), .preset(c_pre[8*k +: 8]), .count(c_cnt[8*k +: 8]),
      .tc_n(c_tc_n[k]), .div_pulse(c_pulse[k])
    );
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: apply inputs at the falling edge and push the expected result of the next rising edge
  task automatic step(input string tag, input logic en_n, input logic ld,
                      input logic rl, input logic [7:0] pre);
    exp_t e;
    logic pulse;
    @(negedge clk);
    cnt_en_n = en_n; load_en = ld; reload_on_tc = rl; preset = pre;
    pulse = 1'b0;
    if (ld) m_cnt = pre;
    else if (!en_n) begin
      pulse = (m_cnt == 8'hFF);
      m_cnt = (rl && m_cnt == 8'hFF) ? pre : m_cnt + 8'd1;
    end
    e.tag = tag; e.cnt = m_cnt; e.pulse = pulse;
    q.push_back(e);
  endtask

  // Monitor: sample 5 ns after each rising edge
  always @(posedge clk) begin
    exp_t e;
    #5;
    cyc++;
    if (rst_n && div_pulse) begin
      if (prev_pulse >= 0) measured = cyc - prev_pulse;
      prev_pulse = cyc;
    end
    if (q.size() > 0) begin
      e = q.pop_front();
      check({e.tag, " count"}, 32'(count), 32'(e.cnt));
      check("R5 tc_n", 32'(tc_n), 32'(e.cnt != 8'hFF));
      check({e.tag, " div_pulse"}, 32'(div_pulse), 32'(e.pulse));
    end
  end

  task automatic period(input logic [7:0] pre, input int expect_n);
    step("R4", 1'b0, 1'b1, 1'b1, pre);
    @(negedge clk);
    prev_pulse = -1; measured = 0;
    for (int i = 0; i < 2 * expect_n + 3; i++) step("R6", 1'b0, 1'b0, 1'b1, pre);
    @(posedge clk); #6;
    check($sformatf("R7 period preset %0d", pre), measured, expect_n);
  endtask

  task automatic cascade(input logic [31:0] start, input int n);
    logic [31:0] r;
    @(negedge clk);
    c_load = 1'b1; c_pre = start;
    @(posedge clk); #5;
    check("R8 load", c_cnt, start);
    c_load = 1'b0;
    r = start;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      r = r + 32'd1;
      check("R8 cascade", c_cnt, r);
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count", 32'(count), 32'd0);
    check("R1 tc_n", 32'(tc_n), 32'd1);
    check("R1 div_pulse", 32'(div_pulse), 32'd0);
    rst_n = 1'b1;
    m_cnt = '0;

    for (int i = 0; i < 10; i++) step("R2", 1'b0, 1'b0, 1'b0, 8'h55);
    step("R4", 1'b1, 1'b1, 1'b0, 8'hF8);
    for (int i = 0; i < 12; i++) step("R2", 1'b0, 1'b0, 1'b0, 8'h11);
    for (int i = 0; i < 4; i++) step("R3", 1'b1, 1'b0, i[0], 8'(i * 37));
    step("R4", 1'b1, 1'b1, 1'b0, 8'hFF);
    step("R4", 1'b0, 1'b1, 1'b1, 8'h3C);
    step("R4", 1'b0, 1'b1, 1'b1, 8'hFD);
    for (int i = 0; i < 5; i++) step("R6", 1'b0, 1'b0, 1'b1, 8'h40);
    step("R4", 1'b0, 1'b1, 1'b0, 8'hFF);
    for (int i = 0; i < 3; i++) step("R9", 1'b1, 1'b0, 1'b1, 8'h20);

    period(8'd143, 113);
    period(8'd0, 256);
    period(8'd200, 56);
    period(8'd255, 1);
    step("R3", 1'b1, 1'b0, 1'b0, 8'h00);
    @(posedge clk); #7;

    cascade(32'h0000_00F8, 20);
    cascade(32'h0000_FFFA, 12);
    cascade(32'h00FF_FFF0, 24);
    cascade(32'hFFFF_FFF0, 24);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule